// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block drives one external memory area over a single shared bus. The same lines carry the address and then the data. An internal client hands it a request made of a byte address, a 3-bit size code and a write flag. The block then runs one address-phase cycle, followed by one data beat, or by a burst of beats when the request is a 32-byte block transfer. The bus data width is a parameter and may be 32 or 64 bits. A 32-byte transfer takes 4 beats on a 64-bit bus and 8 beats on a 32-bit bus.

Requests enter through a valid/ready handshake. A request is taken on any clock edge where `req_valid` and `req_ready` are both high. `req_valid` with its fields must stay stable until that happens. There is no back-pressure on the return side:

- Read data is presented on `rd_data` while `rd_valid` is high, for exactly one cycle per read beat, and must be taken then.
- Write data is not handshaked. During each write beat the client supplies, on `wd_data`, the word whose index inside the aligned 32-byte block appears on `beat_word`.

The external target paces every beat with an active-low ready input. The strobe outputs tell the target where the access starts, which beat is the last one, and when the area is selected.

Top module: `mxb_master`

## Requirements
- R1: `req_ready` is high when the block is idle. It is also high in the cycle where the final data beat completes (the beat is in the data phase and `rdy_n` is low). In every other cycle it is low, and `req_valid` is not taken.
- R2: The address phase lasts exactly one cycle, the one after acceptance. During it:
  - `bs_n` is low;
  - `bus_oe` is high;
  - `bus_dout[25:0]` carries the address and the top three bus bits carry the size code;
  - every other bus bit is 0.
- R3: `cs_n` goes low in the address phase and stays low until the cycle where the final beat completes. It is high whenever the block is idle.
- R4: `frame_n` is low in the address phase and in every data beat except the final one. It is high in the final beat and when idle.
- R5: A size code with bit 2 set (1xx) is a 32-byte burst of 256/BUS_W beats. Codes 000 (byte), 001 (word), 010 (longword) and the unused 011 each take one beat.
- R6: The first data beat uses word index addr[4:log2(BUS_W/8)] inside the aligned 32-byte block. Each later beat adds one to the index, modulo the beat count. `beat_word` shows the index of the current beat.
- R7: A data beat completes only in a cycle where `rdy_n` is low. While `rdy_n` is high, the beat, `beat_word` and the strobes hold, and neither `rd_valid` nor `done` is raised.
- R8: During write beats, `bus_oe` is high and `bus_dout` equals `wd_data`. During read beats, `bus_oe` is low.
- R9: When a read beat completes, `rd_valid` is high for that cycle and `rd_data` equals `bus_din`.
- R10: `done` pulses high in exactly the cycle where the final beat of an access completes.
- R11: A request accepted in the final-beat cycle starts its address phase on the next cycle, with `cs_n` kept low. No idle cycle comes between the two accesses.
- R12: During and right after reset, the outputs are as follows:
  - `cs_n`, `bs_n` and `frame_n` are high;
  - `bus_oe`, `rd_valid` and `done` are low;
  - `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 26 | Byte address of the request |
| req_size | input | 3 | Size code (000 byte, 001 word, 010 longword, 1xx 32-byte burst) |
| req_write | input | 1 | 1 = write, 0 = read |
| wd_data | input | BUS_W | Write word for the beat given by `beat_word` |
| beat_word | output | log2(256/BUS_W) | Word index of the current data beat |
| rd_valid | output | 1 | Read beat completed, `rd_data` valid |
| rd_data | output | BUS_W | Read word |
| done | output | 1 | Final beat of the access completed |
| cs_n | output | 1 | Area select, active low |
| bs_n | output | 1 | Address-phase strobe, active low |
| frame_n | output | 1 | Low while more beats follow, active low |
| bus_dout | output | BUS_W | Shared bus, outbound value |
| bus_oe | output | 1 | Shared bus output enable |
| bus_din | input | BUS_W | Shared bus, inbound value |
| rdy_n | input | 1 | Target ready, active low |

## Verification
The embedded properties watch several local rules on every cycle:

- the strobe lasts a single cycle and falls inside the select window;
- `frame_n` is high whenever `done` fires;
- a wait cycle freezes the beat;
- `done` never appears without `rdy_n` low;
- the bus is released during read beats;
- a request taken at the final beat leads straight into a new address phase.

Other properties depend on the whole access and only the bench scenarios can show them. These are the exact address word with its size code, the beat count per size code, the wrapping word order of bursts that start mid-block, the write words landing in the right places, the read data returned, and the absence of any gap across back-to-back runs with and without wait states.

// File: rtl/mxb_pkg.sv
package mxb_pkg;
  localparam int ADDR_W = 26;
  localparam int SZ_W   = 3;
  localparam int BLK_BYTES = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } mxb_state_e;

  function automatic int beats_per_block(input int bus_w);
    return (BLK_BYTES * 8) / bus_w;
  endfunction
endpackage

// File: rtl/mxb_beat_seq.sv
module mxb_beat_seq #(
  parameter int BEATS = 4,
  localparam int IDX_W = $clog2(BEATS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] start_idx,
  input  logic             burst,
  input  logic             adv,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  logic [IDX_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= '0;
      remain <= '0;
    end else if (load) begin
      idx    <= start_idx;
      remain <= burst ? IDX_W'(BEATS - 1) : '0;
    end else if (adv && (remain != '0)) begin
      idx    <= idx + 1'b1;
      remain <= remain - 1'b1;
    end
  end

  assign last = (remain == '0);
endmodule

// File: rtl/mxb_bus_drive.sv
module mxb_bus_drive
  import mxb_pkg::*;
#(
  parameter int BUS_W = 64
) (
  input  mxb_state_e          st,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [SZ_W-1:0]     size,
  input  logic                wr,
  input  logic [BUS_W-1:0]    wd_data,
  output logic [BUS_W-1:0]    bus_dout,
  output logic                bus_oe
);
  localparam int GAP_W = BUS_W - ADDR_W - SZ_W;

  logic [BUS_W-1:0] addr_word;

  generate
    if (GAP_W > 0) begin : g_gap
      assign addr_word = {size, {GAP_W{1'b0}}, addr};
    end else begin : g_nogap
      assign addr_word = {size, addr};
    end
  endgenerate

  always_comb begin
    bus_dout = '0;
    bus_oe   = 1'b0;
    unique case (st)
      ST_ADDR: begin
        bus_dout = addr_word;
        bus_oe   = 1'b1;
      end
      ST_DATA: begin
        if (wr) begin
          bus_dout = wd_data;
          bus_oe   = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mxb_ctrl.sv
module mxb_ctrl
  import mxb_pkg::*;
#(
  parameter int BEATS  = 4,
  parameter int LANE_B = 3,
  localparam int IDX_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SZ_W-1:0]   req_size,
  input  logic              req_write,
  input  logic              rdy_n,
  input  logic              seq_last,
  input  logic [IDX_W-1:0]  seq_idx,
  output logic              seq_load,
  output logic [IDX_W-1:0]  seq_start,
  output logic              seq_burst,
  output logic              seq_adv,
  output mxb_state_e        st,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [SZ_W-1:0]   cur_size,
  output logic              cur_wr,
  output logic              cs_n,
  output logic              bs_n,
  output logic              frame_n,
  output logic              rd_valid,
  output logic              done
);
  mxb_state_e st_nx;
  logic beat_end, final_end, accept;

  assign beat_end  = (st == ST_DATA) && !rdy_n;
  assign final_end = beat_end && seq_last;
  assign req_ready = (st == ST_IDLE) || final_end;
  assign accept    = req_valid && req_ready;

  assign seq_load  = accept;
  assign seq_start = req_addr[LANE_B +: IDX_W];
  assign seq_burst = req_size[SZ_W-1];
  assign seq_adv   = beat_end;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (accept) st_nx = ST_ADDR;
      ST_ADDR: st_nx = ST_DATA;
      ST_DATA: if (final_end) st_nx = accept ? ST_ADDR : ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cur_addr <= '0;
      cur_size <= '0;
      cur_wr   <= 1'b0;
    end else begin
      st <= st_nx;
      if (accept) begin
        cur_addr <= req_addr;
        cur_size <= req_size;
        cur_wr   <= req_write;
      end
    end
  end

  assign cs_n     = (st == ST_IDLE);
  assign bs_n     = (st != ST_ADDR);
  assign frame_n  = !((st == ST_ADDR) || ((st == ST_DATA) && !seq_last));
  assign rd_valid = beat_end && !cur_wr;
  assign done     = final_end;

  AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> req_ready); // R1
  AST_BS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bs_n |=> bs_n); // R2
  AST_CS_COVERS_BS: assert property (@(posedge clk) disable iff (!rst_n)
    !bs_n |-> !cs_n); // R3
  AST_FRAME_OFF_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> frame_n); // R4
  AST_WAIT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_DATA) && rdy_n) |=> ((st == ST_DATA) && $stable(seq_idx) && !cs_n)); // R7
  AST_DONE_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rdy_n); // R10
  AST_B2B_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && req_valid) |=> (!cs_n && !bs_n)); // R11
endmodule

// File: rtl/mxb_master.sv
module mxb_master
  import mxb_pkg::*;
#(
  parameter int BUS_W = 64,
  localparam int BEATS  = beats_per_block(BUS_W),
  localparam int LANE_B = $clog2(BUS_W / 8),
  localparam int IDX_W  = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SZ_W-1:0]   req_size,
  input  logic              req_write,
  input  logic [BUS_W-1:0]  wd_data,
  output logic [IDX_W-1:0]  beat_word,
  output logic              rd_valid,
  output logic [BUS_W-1:0]  rd_data,
  output logic              done,
  output logic              cs_n,
  output logic              bs_n,
  output logic              frame_n,
  output logic [BUS_W-1:0]  bus_dout,
  output logic              bus_oe,
  input  logic [BUS_W-1:0]  bus_din,
  input  logic              rdy_n
);
  mxb_state_e        st;
  logic [ADDR_W-1:0] cur_addr;
  logic [SZ_W-1:0]   cur_size;
  logic              cur_wr;
  logic              seq_load, seq_burst, seq_adv, seq_last;
  logic [IDX_W-1:0]  seq_start, seq_idx;

  mxb_ctrl #(.BEATS(BEATS), .LANE_B(LANE_B)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .rdy_n(rdy_n), .seq_last(seq_last), .seq_idx(seq_idx),
    .seq_load(seq_load), .seq_start(seq_start), .seq_burst(seq_burst), .seq_adv(seq_adv),
    .st(st), .cur_addr(cur_addr), .cur_size(cur_size), .cur_wr(cur_wr),
    .cs_n(cs_n), .bs_n(bs_n), .frame_n(frame_n), .rd_valid(rd_valid), .done(done)
  );

  mxb_beat_seq #(.BEATS(BEATS)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(seq_load), .start_idx(seq_start),
    .burst(seq_burst), .adv(seq_adv), .idx(seq_idx), .last(seq_last)
  );

  mxb_bus_drive #(.BUS_W(BUS_W)) u_drive (
    .st(st), .addr(cur_addr), .size(cur_size), .wr(cur_wr),
    .wd_data(wd_data), .bus_dout(bus_dout), .bus_oe(bus_oe)
  );

  assign beat_word = seq_idx;
  assign rd_data   = bus_din;

  AST_ADDR_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !bs_n |-> bus_oe); // R2
  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && bs_n && !cur_wr) |-> !bus_oe); // R8
endmodule

// File: tb/mxb_master_bench.sv
`timescale 1ns/1ps
module mxb_master_bench;
  localparam int BUS_W = 64;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_write, rd_valid, done;
  logic cs_n, bs_n, frame_n, bus_oe, rdy_n;
  logic [25:0] req_addr;
  logic [2:0]  req_size;
  logic [BUS_W-1:0] wd_data, rd_data, bus_dout, bus_din;
  logic [1:0] beat_word;

  mxb_master #(.BUS_W(BUS_W)) u_mxb_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .wd_data(wd_data), .beat_word(beat_word), .rd_valid(rd_valid), .rd_data(rd_data),
    .done(done), .cs_n(cs_n), .bs_n(bs_n), .frame_n(frame_n),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din), .rdy_n(rdy_n)
  );

  typedef struct {
    logic [25:0] addr;
    logic [2:0]  size;
    logic        wr;
    int          tag;
  } item_t;

  item_t exp_q[$];
  logic [63:0] mem [64];
  int n_tests = 0;
  int n_fail  = 0;
  int cur_tag = 0;
  bit slow = 0;

  function automatic logic [63:0] wfun(input int tag, input logic [1:0] w);
    return (64'(tag) << 32) | 64'h0000_0000_5A00_0000 | 64'(w);
  endfunction

  assign wd_data = wfun(cur_tag, beat_word);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
    end
  endtask

  // target model and monitor: drives rdy_n/bus_din at negedge, samples 3 ns later
  int ph = 0;
  int nb = 1, cnt = 0, wc = 0;
  logic [1:0] word = '0;
  item_t cur;

  initial begin
    rdy_n = 1'b1;
    bus_din = '0;
    forever begin
      @(negedge clk);
      if (ph == 2) begin
        wc++;
        rdy_n   = slow ? ((wc % 3) != 0) : 1'b0;
        bus_din = cur.wr ? '0 : mem[{cur.addr[8:5], word}];
      end else begin
        rdy_n   = 1'b1;
        bus_din = '0;
      end
      #3;
      if (!rst_n) begin
        ph = 0;
        continue;
      end
      chk(cs_n == (ph == 0), "R3 cs_n", 64'(cs_n), 64'(ph == 0));
      chk(bs_n == (ph != 1), "R2 bs_n", 64'(bs_n), 64'(ph != 1));
      chk(req_ready == ((ph == 0) || (ph == 2 && !rdy_n && cnt == nb - 1)), "R1 req_ready",
          64'(req_ready), 64'((ph == 0) || (ph == 2 && !rdy_n && cnt == nb - 1)));
      if (ph == 0) begin
        chk(frame_n == 1'b1, "R4 frame_n idle", 64'(frame_n), 64'd1);
        chk(!done && !rd_valid, "R10 no done idle", 64'(done), 64'd0);
        if (req_valid && req_ready) ph = 1;
      end else if (ph == 1) begin
        chk(exp_q.size() > 0, "R2 unexpected address phase", 64'(exp_q.size()), 64'd1);
        if (exp_q.size() > 0) begin
          cur = exp_q.pop_front();
          chk(bus_dout == ((64'(cur.size) << 61) | 64'(cur.addr)), "R2 address word",
              bus_dout, (64'(cur.size) << 61) | 64'(cur.addr));
        end
        chk(bus_oe == 1'b1, "R2 bus_oe", 64'(bus_oe), 64'd1);
        chk(frame_n == 1'b0, "R4 frame_n addr", 64'(frame_n), 64'd0);
        cur_tag = cur.tag;
        nb   = cur.size[2] ? 4 : 1; // R5
        cnt  = 0;
        word = cur.addr[4:3];
        wc   = 0;
        ph   = 2;
      end else begin
        chk(bus_oe == cur.wr, "R8 bus_oe data", 64'(bus_oe), 64'(cur.wr));
        chk(frame_n == (cnt == nb - 1), "R4 frame_n data", 64'(frame_n), 64'(cnt == nb - 1));
        if (rdy_n) begin
          chk(!rd_valid && !done, "R7 wait holds", {62'd0, rd_valid, done}, 64'd0);
        end else begin
          chk(beat_word == word, "R6 beat order", 64'(beat_word), 64'(word));
          if (cur.wr) begin
            chk(bus_dout == wfun(cur.tag, word), "R8 write data", bus_dout, wfun(cur.tag, word));
            mem[{cur.addr[8:5], word}] = bus_dout;
          end else begin
            chk(rd_valid && rd_data == mem[{cur.addr[8:5], word}], "R9 read data",
                rd_data, mem[{cur.addr[8:5], word}]);
          end
          chk(done == (cnt == nb - 1), "R10 done", 64'(done), 64'(cnt == nb - 1));
          if (cnt == nb - 1) begin
            ph = (req_valid && req_ready) ? 1 : 0; // R11
          end else begin
            cnt++;
            word++;
          end
        end
      end
    end
  end

  // driver: offers a request and pushes the expected item once it is taken
  task automatic send(input logic [25:0] a, input logic [2:0] s, input logic w, input int tag);
    bit got;
    item_t it;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    req_size  = s;
    req_write = w;
    do begin
      #2;
      got = req_ready;
      if (!got) @(negedge clk);
    end while (!got);
    it.addr = a; it.size = s; it.wr = w; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic stop_req();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(posedge clk);
    while (ph != 0) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 64'hC0DE_0000_0000_0000 | 64'(i * 257);
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0; req_write = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); #3;
    chk(cs_n && bs_n && frame_n, "R12 strobes in reset", {61'd0, cs_n, bs_n, frame_n}, 64'd7);
    chk(!bus_oe && !rd_valid && !done, "R12 idle outputs", {61'd0, bus_oe, rd_valid, done}, 64'd0);
    chk(req_ready, "R12 ready in reset", 64'(req_ready), 64'd1);
    @(negedge clk);
    rst_n = 1'b1;
    #3;
    chk(cs_n && bs_n && frame_n && req_ready, "R12 after reset", {60'd0, cs_n, bs_n, frame_n, req_ready}, 64'd15);

    // single reads of each size, back to back (R5, R11)
    send(26'h0000_010, 3'b000, 1'b0, 1);
    send(26'h0000_048, 3'b001, 1'b0, 2);
    send(26'h0000_078, 3'b010, 1'b0, 3);
    stop_req();
    wait_idle();

    // write then read back (R8, R9)
    send(26'h0000_020, 3'b010, 1'b1, 4);
    stop_req();
    wait_idle();
    send(26'h0000_020, 3'b010, 1'b0, 5);
    stop_req();
    wait_idle();

    // burst read starting at word 2, wraps (R5, R6)
    send(26'h00000D0, 3'b100, 1'b0, 6);
    stop_req();
    wait_idle();

    // slow target: burst write from word 3 then burst read, held request (R1, R7)
    slow = 1;
    send(26'h00001F8, 3'b111, 1'b1, 7);
    send(26'h00001F8, 3'b100, 1'b0, 8);
    stop_req();
    wait_idle();
    slow = 0;

    // unused code takes one beat (R5)
    send(26'h0000_108, 3'b011, 1'b0, 9);
    stop_req();
    wait_idle();

    // back-to-back bursts at minimum pitch (R11)
    send(26'h0000_140, 3'b100, 1'b1, 10);
    send(26'h0000_148, 3'b100, 1'b0, 11);
    send(26'h0000_180, 3'b001, 1'b1, 12);
    stop_req();
    wait_idle();

    chk(exp_q.size() == 0, "R2 all requests ran", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule